// File: doc/BRIEF.md
# Block Cipher Host Sequencer

This block connects a byte-wide CPU/DMA register bus to a 128-bit block-cipher datapath. Software programs a mode and a direction and writes a start command. The sequencer then raises a download request so that a DMA channel feeds the input register. Once enough bytes have arrived, it runs the cipher step. It then raises an upload request so that a second DMA channel drains the output register. When a whole 128-bit block is done, it sets a completion flag. That flag drives the interrupt line when interrupts are enabled, and the interrupt handler usually issues the next start.

The transfer unit depends on the mode. The two whole-block modes, the chained-MAC mode and the two spare codes move all 16 bytes in before any result leaves. The three stream modes cut a block into four 4-byte segments, and each segment's result is read out before the next segment goes in. A lightweight per-byte keyed scramble stands in for the real cipher, so the sequencing can be exercised on its own. A message authentication code is produced by running every block but the last in chained-MAC mode, then switching to the chained mode for the final block. A separate power-resume input clears every register, just as a return from deep sleep would.

Top module: `blk_cipher_hostseq`

## Requirements
- R1: After reset, the control/status byte reads 0x80 (ready set, every other field zero), and the download request, upload request and interrupt outputs are 0.
- R2: Address 0 is control/status, with bit0 = start (write 1, always reads 0), bits[3:1] = mode, bit4 = decrypt, bit5 = done flag, bit6 = interrupt enable and bit7 = ready (read-only). Address 1 is the data-in register, written only. Address 2 is the data-out register. Reads at address 1 and address 3 return 0.
- R3: Writing the control/status byte with bit0 = 1 while ready is 1 clears ready and raises the download request in the next cycle. A start written while busy is ignored.
- R4: Mode codes 0 (whole-block), 1 (chained), 5 (chained-MAC) and the spare codes 6 and 7 keep the download request high for exactly 16 data-in writes. After processing, the upload request stays high for exactly 16 data-out reads.
- R5: Mode codes 2, 3 and 4 (stream modes) run four rounds. Each round takes 4 data-in writes under the download request, then 4 data-out reads under the upload request.
- R6: For byte position i (0 to 15) in the block, let m(i) = 0x3C XOR low8(29·i). Encryption outputs rotate-left-1(x) XOR m(i), and decryption outputs rotate-right-1(x XOR m(i)). Decryption therefore inverts encryption.
- R7: After the last data-out read of a block, ready and the done flag are 1. The mode and decrypt fields keep the values programmed at start, and the interrupt output equals done flag AND interrupt enable.
- R8: Writing the control/status byte with bit5 = 0 clears the done flag. Writing bit5 = 1 never sets it. Completion in the same cycle wins over a clear.
- R9: A data-out read outside the upload phase returns 0 and does not advance the sequence. A data-in write outside the download phase has no effect on the data or on the byte counts.
- R10: While busy, writes to the mode and decrypt fields are ignored. The interrupt enable stays writable at all times.
- R11: A one-cycle pulse on the power-resume input returns every register to its reset value, including in the middle of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_resume | input | 1 | Synchronous clear when returning from deep sleep |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops data-out during upload |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| dl_req | output | 1 | Download request: data-in wants bytes |
| ul_req | output | 1 | Upload request: data-out holds result bytes |
| irq | output | 1 | Completion interrupt (done flag AND enable) |

## Verification
The bench builds the block with its default values: a 16-byte block, 4-byte segments and a 3-cycle processing delay. With these values both transfer granularities and the segment-to-segment turnaround are reached in short runs, and a byte that lands in the wrong lane shows up as a wrong mask. A random mix of all eight mode codes, both directions and random data is checked against a bench model of the scramble. Directed cases add busy starts, stray bus accesses, flag clear and set races, and a power-resume pulse in the middle of a block.

// File: rtl/hsq_pkg.sv
package hsq_pkg;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DIN  = 2'd1;
  localparam logic [1:0] A_DOUT = 2'd2;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOAD = 2'd1,
    S_PROC = 2'd2,
    S_UNLD = 2'd3
  } seq_st_e;

  // stream modes move 32-bit segments; all others move whole blocks
  function automatic logic is_stream(input logic [2:0] md);
    return (md == 3'd2) || (md == 3'd3) || (md == 3'd4);
  endfunction

  function automatic logic [7:0] lane_mask(input int lane);
    logic [7:0] p;
    p = 8'(lane * 29);
    return 8'h3C ^ p;
  endfunction

  function automatic logic [7:0] enc_byte(input logic [7:0] b, input int lane);
    return {b[6:0], b[7]} ^ lane_mask(lane);
  endfunction

  function automatic logic [7:0] dec_byte(input logic [7:0] b, input int lane);
    logic [7:0] t;
    t = b ^ lane_mask(lane);
    return {t[0], t[7:1]};
  endfunction

endpackage

// File: rtl/hsq_csr.sv
module hsq_csr
  import hsq_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       clr_i,
  input  logic       wr_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       busy_i,
  input  logic       done_i,
  output logic       start_o,
  output logic       stream_o,
  output logic       dec_o,
  output logic [7:0] ctrl_o,
  output logic       irq_o
);

  logic       wr_ctl;
  logic [2:0] mode_q, mode_d;
  logic       dec_q, dec_d;
  logic       ien_q, ien_d;
  logic       flag_q, flag_d;
  logic       cfg_en;

  assign wr_ctl   = wr_i && (addr_i == A_CTRL);
  assign cfg_en   = wr_ctl && !busy_i;
  assign start_o  = cfg_en && wdata_i[0];
  assign stream_o = is_stream(wdata_i[3:1]);

  always_comb begin
    mode_d = mode_q;
    dec_d  = dec_q;
    ien_d  = ien_q;
    flag_d = flag_q;
    if (cfg_en) begin
      mode_d = wdata_i[3:1];
      dec_d  = wdata_i[4];
    end
    if (wr_ctl) begin
      ien_d = wdata_i[6];
      if (!wdata_i[5]) flag_d = 1'b0;
    end
    if (done_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mode_q <= 3'd0;
      dec_q  <= 1'b0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (clr_i) begin
      mode_q <= 3'd0;
      dec_q  <= 1'b0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      dec_q  <= dec_d;
      ien_q  <= ien_d;
      flag_q <= flag_d;
    end
  end

  assign dec_o  = dec_q;
  assign ctrl_o = {~busy_i, ien_q, flag_q, dec_q, mode_q, 1'b0};
  assign irq_o  = flag_q & ien_q;

  // R7
  flag_src_chk: assert property (@(posedge clk) disable iff (!arst_n || clr_i)
    (!flag_q && !done_i) |=> !flag_q);

  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (!arst_n || clr_i)
    (wr_ctl && !wdata_i[5] && !done_i) |=> !flag_q);

  // R10
  mode_lock_chk: assert property (@(posedge clk) disable iff (!arst_n || clr_i)
    busy_i |=> (mode_q == $past(mode_q)) && (dec_q == $past(dec_q)));

endmodule

// File: rtl/hsq_fsm.sv
module hsq_fsm
  import hsq_pkg::*;
#(
  parameter int BLK_BYTES = 16,
  parameter int SEG_BYTES = 4,
  parameter int PROC_CYC  = 3
) (
  input  logic                         clk,
  input  logic                         arst_n,
  input  logic                         clr_i,
  input  logic                         start_i,
  input  logic                         stream_i,
  input  logic                         din_we_i,
  input  logic                         dout_re_i,
  output logic                         dl_req_o,
  output logic                         ul_req_o,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         buf_we_o,
  output logic                         xf_go_o,
  output logic [$clog2(BLK_BYTES)-1:0] ld_idx_o,
  output logic [$clog2(BLK_BYTES)-1:0] rd_idx_o
);

  localparam int IW = $clog2(BLK_BYTES + 1);
  localparam int AW = $clog2(BLK_BYTES);
  localparam int PW = (PROC_CYC > 1) ? $clog2(PROC_CYC) : 1;
  localparam logic [IW-1:0] BLK_N = IW'(BLK_BYTES);
  localparam logic [IW-1:0] SEG_N = IW'(SEG_BYTES);
  localparam logic [PW-1:0] PC_LD = PW'(PROC_CYC - 1);

  seq_st_e       st_q, st_d;
  logic [IW-1:0] ld_q, ld_d, ul_q, ul_d, se_q, se_d;
  logic [PW-1:0] pc_q, pc_d;
  logic [IW-1:0] ld_inc, ul_inc;

  assign ld_inc = ld_q + IW'(1);
  assign ul_inc = ul_q + IW'(1);

  always_comb begin
    st_d   = st_q;
    ld_d   = ld_q;
    ul_d   = ul_q;
    se_d   = se_q;
    pc_d   = pc_q;
    done_o = 1'b0;
    case (st_q)
      S_IDLE: if (start_i) begin
        st_d = S_LOAD;
        ld_d = '0;
        ul_d = '0;
        se_d = stream_i ? SEG_N : BLK_N;
      end
      S_LOAD: if (din_we_i) begin
        ld_d = ld_inc;
        if (ld_inc == se_q) begin
          st_d = S_PROC;
          pc_d = PC_LD;
        end
      end
      S_PROC: begin
        if (pc_q == '0) st_d = S_UNLD;
        else            pc_d = pc_q - PW'(1);
      end
      S_UNLD: if (dout_re_i) begin
        ul_d = ul_inc;
        if (ul_inc == se_q) begin
          if (se_q == BLK_N) begin
            st_d   = S_IDLE;
            done_o = 1'b1;
          end else begin
            se_d = se_q + SEG_N;
            st_d = S_LOAD;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q <= S_IDLE;
      ld_q <= '0;
      ul_q <= '0;
      se_q <= '0;
      pc_q <= '0;
    end else if (clr_i) begin
      st_q <= S_IDLE;
      ld_q <= '0;
      ul_q <= '0;
      se_q <= '0;
      pc_q <= '0;
    end else begin
      st_q <= st_d;
      ld_q <= ld_d;
      ul_q <= ul_d;
      se_q <= se_d;
      pc_q <= pc_d;
    end
  end

  assign dl_req_o = (st_q == S_LOAD);
  assign ul_req_o = (st_q == S_UNLD);
  assign busy_o   = (st_q != S_IDLE);
  assign buf_we_o = (st_q == S_LOAD) && din_we_i;
  assign xf_go_o  = (st_q == S_PROC) && (pc_q == '0);
  assign ld_idx_o = ld_q[AW-1:0];
  assign rd_idx_o = ul_q[AW-1:0];

  // R3
  start_dl_chk: assert property (@(posedge clk) disable iff (!arst_n || clr_i)
    (st_q == S_IDLE && start_i) |=> dl_req_o);

  // R9
  ld_hold_chk: assert property (@(posedge clk) disable iff (!arst_n || clr_i)
    (busy_o && !buf_we_o) |=> (ld_q == $past(ld_q)));

  // R4
  ptr_order_chk: assert property (@(posedge clk) disable iff (!arst_n || clr_i)
    busy_o |-> (ul_q <= ld_q));

  // R5
  seg_bound_chk: assert property (@(posedge clk) disable iff (!arst_n || clr_i)
    busy_o |-> (se_q <= BLK_N && se_q != '0));

endmodule

// File: rtl/hsq_dpath.sv
module hsq_dpath
  import hsq_pkg::*;
#(
  parameter int BLK_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         arst_n,
  input  logic                         clr_i,
  input  logic                         buf_we_i,
  input  logic [$clog2(BLK_BYTES)-1:0] ld_idx_i,
  input  logic [7:0]                   wdata_i,
  input  logic                         xf_go_i,
  input  logic                         dec_i,
  input  logic                         ul_act_i,
  input  logic [$clog2(BLK_BYTES)-1:0] rd_idx_i,
  output logic [7:0]                   dout_o
);

  logic [BLK_BYTES-1:0][7:0] in_q, in_d, out_q, out_d, xf;

  // placeholder cipher: one keyed scramble lane per byte position
  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
    assign xf[g] = dec_i ? dec_byte(in_q[g], g) : enc_byte(in_q[g], g);
  end

  always_comb begin
    in_d  = in_q;
    out_d = out_q;
    if (buf_we_i) in_d[ld_idx_i] = wdata_i;
    if (xf_go_i)  out_d = xf;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else if (clr_i) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      in_q  <= in_d;
      out_q <= out_d;
    end
  end

  assign dout_o = ul_act_i ? out_q[rd_idx_i] : 8'h00;

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!arst_n || clr_i)
    !xf_go_i |=> $stable(out_q));

endmodule

// File: rtl/blk_cipher_hostseq.sv
module blk_cipher_hostseq
  import hsq_pkg::*;
#(
  parameter int BLK_BYTES = 16,
  parameter int SEG_BYTES = 4,
  parameter int PROC_CYC  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_resume,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       dl_req,
  output logic       ul_req,
  output logic       irq
);

  localparam int AW = $clog2(BLK_BYTES);

  logic [1:0]    rs_q;
  logic          arst_n;
  logic          start, stream, dec, busy, done;
  logic          buf_we, xf_go;
  logic [AW-1:0] ld_idx, rd_idx;
  logic [7:0]    ctrl_byte, dout_byte;
  logic          din_we, dout_re;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  assign din_we  = bus_wr && (bus_addr == A_DIN);
  assign dout_re = bus_rd && (bus_addr == A_DOUT);

  hsq_csr u_csr (
    .clk      (clk),
    .arst_n   (arst_n),
    .clr_i    (pwr_resume),
    .wr_i     (bus_wr),
    .addr_i   (bus_addr),
    .wdata_i  (bus_wdata),
    .busy_i   (busy),
    .done_i   (done),
    .start_o  (start),
    .stream_o (stream),
    .dec_o    (dec),
    .ctrl_o   (ctrl_byte),
    .irq_o    (irq)
  );

  hsq_fsm #(
    .BLK_BYTES (BLK_BYTES),
    .SEG_BYTES (SEG_BYTES),
    .PROC_CYC  (PROC_CYC)
  ) u_fsm (
    .clk       (clk),
    .arst_n    (arst_n),
    .clr_i     (pwr_resume),
    .start_i   (start),
    .stream_i  (stream),
    .din_we_i  (din_we),
    .dout_re_i (dout_re),
    .dl_req_o  (dl_req),
    .ul_req_o  (ul_req),
    .busy_o    (busy),
    .done_o    (done),
    .buf_we_o  (buf_we),
    .xf_go_o   (xf_go),
    .ld_idx_o  (ld_idx),
    .rd_idx_o  (rd_idx)
  );

  hsq_dpath #(
    .BLK_BYTES (BLK_BYTES)
  ) u_dpath (
    .clk      (clk),
    .arst_n   (arst_n),
    .clr_i    (pwr_resume),
    .buf_we_i (buf_we),
    .ld_idx_i (ld_idx),
    .wdata_i  (bus_wdata),
    .xf_go_i  (xf_go),
    .dec_i    (dec),
    .ul_act_i (ul_req),
    .rd_idx_i (rd_idx),
    .dout_o   (dout_byte)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_byte;
      A_DOUT:  bus_rdata = dout_byte;
      default: bus_rdata = 8'h00;
    endcase
  end

  // R9
  req_excl_chk: assert property (@(posedge clk) disable iff (!arst_n || pwr_resume)
    !(dl_req && ul_req));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!arst_n || pwr_resume)
    (irq && !busy) |-> ctrl_byte[5] && ctrl_byte[6]);

endmodule

// File: tb/blk_cipher_hostseq_tb.sv
module blk_cipher_hostseq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_resume = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       dl_req, ul_req, irq;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  ien_sh = 1'b0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  blk_cipher_hostseq u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_resume(pwr_resume),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dl_req(dl_req), .ul_req(ul_req), .irq(irq)
  );

  function automatic logic [7:0] exp_byte(input logic [7:0] b, input int i, input logic dc);
    logic [7:0] m, t;
    m = 8'h3C ^ 8'(i * 29);
    if (!dc) return {b[6:0], b[7]} ^ m;
    t = b ^ m;
    return {t[0], t[7:1]};
  endfunction

  function automatic bit stream_md(input logic [2:0] md);
    return (md == 3'd2 || md == 3'd3 || md == 3'd4);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  // inj: 0 none, 1 stray read + busy start during load, 2 stray din write during upload
  task automatic run_block(input logic [2:0] md, input logic dc, input logic [127:0] pt,
                           input int inj, output logic [127:0] ct);
    int seg, nseg;
    bit gok, dok;
    logic [7:0] d, e;
    seg = stream_md(md) ? 4 : 16;
    nseg = 16 / seg;
    gok = 1'b1; dok = 1'b1; ct = '0;
    wr(2'd0, {1'b0, ien_sh, 1'b1, dc, md, 1'b1});
    for (int s = 0; s < nseg; s++) begin
      for (int b = 0; b < seg; b++) begin
        int i;
        i = s * seg + b;
        @(negedge clk);
        if (!dl_req || ul_req) gok = 1'b0;
        if (inj == 1 && i == 1) begin
          rd(2'd2, d);
          chk(d == 8'h00, "R9 stray dout read", d, 0);
          wr(2'd0, {1'b0, ien_sh, 1'b1, ~dc, 3'd3, 1'b1});
        end
        wr(2'd1, pt[i*8 +: 8]);
      end
      @(negedge clk);
      if (dl_req) gok = 1'b0;
      for (int w = 0; w < 64 && !ul_req; w++) @(negedge clk);
      if (!ul_req) gok = 1'b0;
      for (int b = 0; b < seg; b++) begin
        int i;
        i = s * seg + b;
        if (!ul_req) gok = 1'b0;
        rd(2'd2, d);
        e = exp_byte(pt[i*8 +: 8], i, dc);
        ct[i*8 +: 8] = d;
        if (d !== e) dok = 1'b0;
        if (inj == 2 && b == 0) wr(2'd1, 8'hFF);
      end
      @(negedge clk);
      if (s < nseg - 1) begin
        if (!dl_req || ul_req) gok = 1'b0;
      end else if (dl_req || ul_req) gok = 1'b0;
    end
    chk(gok, stream_md(md) ? "R5 segment granularity" : "R4 block granularity", {125'd0, md}, 0);
    chk(dok, inj == 2 ? "R9 stray din write" : "R6 transform", ct, 0);
    rd(2'd0, d);
    e = {1'b1, ien_sh, 1'b1, dc, md, 1'b0};
    chk(d == e, inj == 1 ? "R10 fields locked while busy" : "R7 completion status", d, e);
    chk(irq === ien_sh, "R7 irq gating", irq, ien_sh);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic [127:0] pt, ct, ct2;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(2'd0, d);
    chk(d == 8'h80, "R1 ctrl reset", d, 8'h80);
    chk(!dl_req && !ul_req && !irq, "R1 outputs reset", {dl_req, ul_req, irq}, 0);
    // R2 map, R9 idle dout read
    rd(2'd3, d); chk(d == 8'h00, "R2 addr3 reads 0", d, 0);
    rd(2'd1, d); chk(d == 8'h00, "R2 din reads 0", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R9 idle dout read", d, 0);
    wr(2'd1, 8'h5A);
    chk(!dl_req && !ul_req, "R9 idle din write", {dl_req, ul_req}, 0);

    // directed blocks
    pt = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    run_block(3'd0, 1'b0, pt, 0, ct);
    run_block(3'd2, 1'b0, pt, 0, ct);
    // R6 roundtrip through a stream mode
    run_block(3'd4, 1'b0, pt, 0, ct);
    run_block(3'd4, 1'b1, ct, 0, ct2);
    chk(ct2 == pt, "R6 decrypt inverts encrypt", ct2, pt);
    // CBC-MAC style: chained-MAC blocks, then chained for the last
    run_block(3'd5, 1'b0, pt, 0, ct);
    run_block(3'd1, 1'b0, ct, 0, ct2);
    // R3 R10 busy start ignored, R9 stray accesses
    run_block(3'd0, 1'b0, pt, 1, ct);
    run_block(3'd3, 1'b1, pt, 2, ct);

    // R8 flag handling, R7 irq gating
    wr(2'd0, 8'h60);
    chk(irq === 1'b1, "R7 irq with enable", irq, 1);
    wr(2'd0, 8'h40);
    rd(2'd0, d);
    chk(d[5] == 1'b0 && irq == 1'b0, "R8 flag clear by 0", d, 8'hC0);
    wr(2'd0, 8'h20);
    rd(2'd0, d);
    chk(d == 8'h80, "R8 writing 1 does not set", d, 8'h80);

    // R3 start visibility then R11 power-resume mid block
    wr(2'd0, 8'h41);
    @(negedge clk);
    chk(dl_req === 1'b1, "R3 dl_req after start", dl_req, 1);
    rd(2'd0, d);
    chk(d[7] == 1'b0, "R3 ready cleared", d, 8'h40);
    wr(2'd1, 8'h11);
    wr(2'd1, 8'h22);
    @(negedge clk); pwr_resume = 1'b1;
    @(negedge clk); pwr_resume = 1'b0;
    rd(2'd0, d);
    chk(d == 8'h80, "R11 ctrl after resume", d, 8'h80);
    chk(!dl_req && !ul_req && !irq, "R11 outputs after resume", {dl_req, ul_req, irq}, 0);

    // random blocks
    for (int k = 0; k < 24; k++) begin
      logic [2:0] md;
      logic dc;
      md = 3'($urandom_range(0, 7));
      dc = 1'($urandom_range(0, 1));
      ien_sh = 1'($urandom_range(0, 1));
      pt = {$urandom, $urandom, $urandom, $urandom};
      run_block(md, dc, pt, 0, ct);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule